// File: doc/BRIEF.md
# Ternary-Coded Skew and Divide Clock Bank

This block produces four clock banks from one reference clock level, all timed by a fast tick clock in which one tick stands for one skew time unit. The reference is sampled into a tap line, and each bank takes the tap that lies a programmed number of ticks around a nominal offset of `NOM_TICKS` ticks. A bank can therefore lead the zero-skew position as well as lag it. Each bank has a 4-bit code made of two ternary digits. Banks 1 and 2 use single-tick steps. Banks 3 and 4 use double-tick steps and give their two extreme codes to divide or invert functions.

Each bank lane holds a latched configuration, made up of a mode (`MD_PASS`, `MD_INV`, `MD_DIV2`, `MD_DIV4`) and a tap index. The configuration reloads only when the sampled reference shows a rising edge, so a code change never cuts a reference phase short. Each lane also holds a divider state machine with four named states: `PH_LO_A`, `PH_LO_B`, `PH_HI_A` and `PH_HI_B`.

- In `MD_DIV2`, a rising edge of the lane's delayed reference moves either low state to `PH_HI_A` and either high state to `PH_LO_A`.
- In `MD_DIV4`, each rising edge steps the cycle `PH_LO_A` → `PH_LO_B` → `PH_HI_A` → `PH_HI_B` → `PH_LO_A`.
- In `MD_PASS` and `MD_INV`, the state holds.

The divided output is high in the two `PH_HI` states.

Top module: `skewbank_top`

## Requirements
- R1: While `rst` is high, every tap is cleared, every divider state returns to `PH_LO_A` and each lane loads its configuration from its code. After reset, pass and divided banks are low and an inverted bank is high.
- R2: Each code holds two digits, a first digit in bits [3:2] and a second digit in bits [1:0]. The digit encodings are 00 = L, 01 = M and 10 = H. The value 11 is taken as M.
- R3: Banks 1 and 2 map LL, LM, LH, ML, MM, MH, HL, HM, HH to skews of -4, -3, -2, -1, 0, +1, +2, +3, +4 ticks. The total delay is d = 6 + skew. After clock edge n the bank equals the `ref_in` value sampled at edge n-d, so MM gives a delay of exactly 6.
- R4: Banks 3 and 4 map LM, LH, ML, MM, MH, HL, HM to skews of -6, -4, -2, 0, +2, +4, +6 ticks, with the same delay rule as R3.
- R5: On banks 3 and 4, code LL divides by two. The output toggles one edge after each rising edge of the reference delayed by 6 ticks.
- R6: On bank 3, code HH divides by four. The output stays low across two rising edges of the 6-tick delayed reference and high across the next two.
- R7: On bank 4, code HH drives the complement of the reference delayed by 6 ticks.
- R8: A lane takes a new code only at a clock edge where the two latest reference samples read 0 then 1. At every other edge its mode and delay are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; one period is one skew time unit |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock level, sampled on the tick clock |
| code_b1 | input | 4 | Bank 1 skew code |
| code_b2 | input | 4 | Bank 2 skew code |
| code_b3 | input | 4 | Bank 3 skew/divide code |
| code_b4 | input | 4 | Bank 4 skew/invert code |
| bank_clk | output | 4 | Bank clocks; bit 0 is bank 1 |

## Verification
The assertions assume that `ref_in` and the codes are synchronous to the tick clock and stable around its rising edge. They also assume that a mode change is judged only across two edges with the same latched mode, and that reset has been asserted before the first edge counts. The bench drives every input at the falling edge of the clock. It holds reset for several ticks at start-up, and it changes codes only between ticks. Reference phases last at least three ticks, so the sampled edges stay well-formed for rise detection.

// File: rtl/skewbank_pkg.sv
package skewbank_pkg;

    typedef enum logic [1:0] {
        MD_PASS,
        MD_INV,
        MD_DIV2,
        MD_DIV4
    } mode_e;

    typedef enum logic [1:0] {
        PH_LO_A,
        PH_LO_B,
        PH_HI_A,
        PH_HI_B
    } phase_e;

    // Ternary digit value: 00 -> 0 (L), 10 -> 2 (H), 01/11 -> 1 (M)
    function automatic int digit_level(input logic [1:0] dig);
        if (dig == 2'b00)      return 0;
        else if (dig == 2'b10) return 2;
        else                   return 1;
    endfunction

endpackage

// File: rtl/skewbank_tapline.sv
module skewbank_tapline #(
    parameter int DEPTH = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    output logic [DEPTH-1:0] taps,
    output logic             ref_rise
);

    always_ff @(posedge clk) begin
        if (rst) taps <= '0;
        else     taps <= {taps[DEPTH-2:0], ref_in};
    end

    assign ref_rise = taps[0] & ~taps[1];

endmodule

// File: rtl/skewbank_lane.sv
module skewbank_lane
    import skewbank_pkg::*;
#(
    parameter int NOM      = 6,
    parameter bit WIDE     = 1'b0,
    parameter bit TOP_DIV4 = 1'b0,
    localparam int DEPTH   = 2 * NOM + 2,
    localparam int DW      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] taps,
    input  logic             ref_rise,
    input  logic [3:0]       code,
    output logic             bank_o
);

    mode_e           mode_q, nxt_mode;
    logic [DW-1:0]   dly_q, nxt_dly;
    phase_e          st_q, st_nx;
    int              idx;
    int              sk;
    logic            tap, tap_nx, tap_rise;

    // Code decode into mode and tap index
    always_comb begin
        idx      = 3 * digit_level(code[3:2]) + digit_level(code[1:0]);
        nxt_mode = MD_PASS;
        sk       = 0;
        if (!WIDE)          sk = idx - 4;
        else if (idx == 0)  nxt_mode = MD_DIV2;
        else if (idx == 8)  nxt_mode = TOP_DIV4 ? MD_DIV4 : MD_INV;
        else                sk = 2 * (idx - 4);
        nxt_dly = DW'(NOM + sk);
    end

    // Configuration latch: reload at reset or at a reference rise
    always_ff @(posedge clk) begin
        if (rst || ref_rise) begin
            mode_q <= nxt_mode;
            dly_q  <= nxt_dly;
        end
    end

    assign tap      = taps[dly_q];
    assign tap_nx   = taps[dly_q + DW'(1)];
    assign tap_rise = tap & ~tap_nx;

    // Divider state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= PH_LO_A;
        else     st_q <= st_nx;
    end

    // Divider next state
    always_comb begin
        st_nx = st_q;
        unique case (mode_q)
            MD_DIV2: begin
                if (tap_rise)
                    st_nx = (st_q == PH_HI_A || st_q == PH_HI_B) ? PH_LO_A : PH_HI_A;
            end
            MD_DIV4: begin
                if (tap_rise) begin
                    unique case (st_q)
                        PH_LO_A: st_nx = PH_LO_B;
                        PH_LO_B: st_nx = PH_HI_A;
                        PH_HI_A: st_nx = PH_HI_B;
                        PH_HI_B: st_nx = PH_LO_A;
                    endcase
                end
            end
            MD_PASS, MD_INV: st_nx = st_q;
        endcase
    end

    // Output select
    always_comb begin
        unique case (mode_q)
            MD_PASS:          bank_o = tap;
            MD_INV:           bank_o = ~tap;
            MD_DIV2, MD_DIV4: bank_o = (st_q == PH_HI_A || st_q == PH_HI_B);
        endcase
    end

    // R8: configuration only moves on a reference rise
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ref_rise)) |-> ($stable(mode_q) && $stable(dly_q)));

    // R3/R4: delay never leaves the tap line window
    assert_dly_range_R4: assert property (@(posedge clk) disable iff (rst)
        dly_q <= DW'(2 * NOM));

    // R5: a divided output moves only after a delayed reference rise
    assert_div_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (mode_q == MD_DIV2 || mode_q == MD_DIV4) &&
         $past(mode_q) == mode_q && bank_o != $past(bank_o)) |-> $past(tap_rise));

    // R5: divide-by-two toggles on every delayed reference rise
    assert_div2_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_q == MD_DIV2 && $past(mode_q) == MD_DIV2 &&
         $past(tap_rise)) |-> (bank_o != $past(bank_o)));

    // R6: first rise of a divide-by-four cycle keeps the output low
    assert_div4_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_q == MD_DIV4 && $past(mode_q) == MD_DIV4 &&
         $past(tap_rise) && $past(st_q) == PH_LO_A) |-> (!bank_o && st_q == PH_LO_B));

endmodule

// File: rtl/skewbank_top.sv
module skewbank_top #(
    parameter int NOM_TICKS = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_in,
    input  logic [3:0] code_b1,
    input  logic [3:0] code_b2,
    input  logic [3:0] code_b3,
    input  logic [3:0] code_b4,
    output logic [3:0] bank_clk
);

    localparam int DEPTH  = 2 * NOM_TICKS + 2;
    localparam int NBANKS = 4;

    logic [DEPTH-1:0] taps;
    logic             ref_rise;
    logic [3:0]       codes [NBANKS];

    assign codes[0] = code_b1;
    assign codes[1] = code_b2;
    assign codes[2] = code_b3;
    assign codes[3] = code_b4;

    skewbank_tapline #(.DEPTH(DEPTH)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .ref_in   (ref_in),
        .taps     (taps),
        .ref_rise (ref_rise)
    );

    for (genvar g = 0; g < NBANKS; g++) begin : g_lane
        skewbank_lane #(
            .NOM      (NOM_TICKS),
            .WIDE     (g >= 2),
            .TOP_DIV4 (g == 2)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .taps     (taps),
            .ref_rise (ref_rise),
            .code     (codes[g]),
            .bank_o   (bank_clk[g])
        );
    end

endmodule

// File: tb/skewbank_top_test.sv
`timescale 1ns/1ps
module skewbank_top_test;

    localparam int NOM = 6;
    localparam int HL  = 2 * NOM + 2;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0;
    logic [3:0] code_b1 = 4'b0101, code_b2 = 4'b0101, code_b3 = 4'b0101, code_b4 = 4'b0101;
    logic [3:0] bank_clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    item_t sb [$];

    // bench model state
    logic hb [HL];
    int   m_mode [4];
    int   m_dly  [4];
    int   m_st   [4];

    skewbank_top #(.NOM_TICKS(NOM)) uut (
        .clk(clk), .rst(rst), .ref_in(ref_in),
        .code_b1(code_b1), .code_b2(code_b2), .code_b3(code_b3), .code_b4(code_b4),
        .bank_clk(bank_clk)
    );

    always #2 clk = ~clk;

    function automatic int dlev(input logic [1:0] d);
        case (d)
            2'b00:   return 0;
            2'b10:   return 2;
            default: return 1;
        endcase
    endfunction

    // mode: 0 pass, 1 invert, 2 div2, 3 div4
    task automatic bdec(input int b, input logic [3:0] c, output int md, output int dl);
        int i;
        i  = 3 * dlev(c[3:2]) + dlev(c[1:0]);
        md = 0;
        if (b < 2) dl = NOM + (i - 4);
        else begin
            case (i)
                0: begin md = 2; dl = NOM; end
                1: dl = NOM - 6;
                2: dl = NOM - 4;
                3: dl = NOM - 2;
                4: dl = NOM;
                5: dl = NOM + 2;
                6: dl = NOM + 4;
                7: dl = NOM + 6;
                default: begin md = (b == 2) ? 3 : 1; dl = NOM; end
            endcase
        end
    endtask

    function automatic logic [3:0] cur_code(input int b);
        case (b)
            0: return code_b1;
            1: return code_b2;
            2: return code_b3;
            default: return code_b4;
        endcase
    endfunction

    // Advance the model across the coming rising edge and queue the expected outputs
    task automatic tick(input logic r);
        item_t it;
        logic  rr;
        ref_in = r;
        if (rst) begin
            for (int k = 0; k < HL; k++) hb[k] = 1'b0;
            for (int b = 0; b < 4; b++) begin
                m_st[b] = 0;
                bdec(b, cur_code(b), m_mode[b], m_dly[b]);
            end
        end else begin
            rr = hb[0] & ~hb[1];
            for (int b = 0; b < 4; b++) begin
                if (hb[m_dly[b]] && !hb[m_dly[b] + 1]) begin
                    if (m_mode[b] == 2) m_st[b] = (m_st[b] >= 2) ? 0 : 2;
                    else if (m_mode[b] == 3) m_st[b] = (m_st[b] + 1) % 4;
                end
            end
            if (rr) for (int b = 0; b < 4; b++) bdec(b, cur_code(b), m_mode[b], m_dly[b]);
            for (int k = HL - 1; k > 0; k--) hb[k] = hb[k-1];
            hb[0] = r;
        end
        for (int b = 0; b < 4; b++) begin
            case (m_mode[b])
                0: it.exp[b] = hb[m_dly[b]];
                1: it.exp[b] = ~hb[m_dly[b]];
                default: it.exp[b] = (m_st[b] >= 2);
            endcase
        end
        it.tag = cur_tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic wave(input int hi, input int lo, input int n);
        for (int i = 0; i < n; i++) begin
            repeat (hi) tick(1'b1);
            repeat (lo) tick(1'b0);
        end
    endtask

    // Monitor: compare each result once it has settled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cycles++;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                for (int b = 0; b < 4; b++) begin
                    checks++;
                    if (bank_clk[b] !== it.exp[b]) begin
                        errors++;
                        $display("FAIL %s bank%0d actual=%b expected=%b", it.tag, b + 1, bank_clk[b], it.exp[b]);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        wait (cycles > 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state, with bank 4 inverted so its reset value is high
        cur_tag = "R1";
        code_b4 = 4'b1010;
        code_b3 = 4'b1010;
        repeat (4) tick(1'b0);
        rst = 1'b0;
        repeat (2) tick(1'b0);

        // R3: every single-step code on banks 1 and 2
        cur_tag = "R3";
        code_b3 = 4'b0101; code_b4 = 4'b0101;
        for (int i = 0; i < 9; i++) begin
            logic [1:0] d [3];
            d[0] = 2'b00; d[1] = 2'b01; d[2] = 2'b10;
            code_b1 = {d[i / 3], d[i % 3]};
            code_b2 = {d[(8 - i) / 3], d[(8 - i) % 3]};
            wave(5, 5, 3);
        end

        // R4: double-step codes on banks 3 and 4
        cur_tag = "R4";
        for (int i = 1; i < 8; i++) begin
            logic [1:0] d [3];
            d[0] = 2'b00; d[1] = 2'b01; d[2] = 2'b10;
            code_b3 = {d[i / 3], d[i % 3]};
            code_b4 = {d[(8 - i) / 3], d[(8 - i) % 3]};
            wave(8, 8, 2);
            wave(3, 7, 2);
        end

        // R5: divide by two on banks 3 and 4
        cur_tag = "R5";
        code_b3 = 4'b0000; code_b4 = 4'b0000;
        wave(4, 6, 8);

        // R6 and R7: bank 3 divide by four, bank 4 inverted
        cur_tag = "R6";
        code_b3 = 4'b1010; code_b4 = 4'b1010;
        wave(3, 5, 10);
        cur_tag = "R7";
        wave(6, 9, 4);

        // R8: codes changed in the middle of a reference phase
        cur_tag = "R8";
        code_b1 = 4'b0101; code_b2 = 4'b0101; code_b3 = 4'b0101; code_b4 = 4'b0101;
        wave(6, 6, 2);
        repeat (2) tick(1'b1);
        code_b1 = 4'b0000; code_b2 = 4'b1010; code_b3 = 4'b0001; code_b4 = 4'b1001;
        repeat (4) tick(1'b1);
        repeat (3) tick(1'b0);
        code_b1 = 4'b1000; code_b3 = 4'b0000;
        repeat (3) tick(1'b0);
        wave(6, 6, 3);

        // R2: digit value 11 is taken as M
        cur_tag = "R2";
        code_b1 = 4'b1111; code_b2 = 4'b1101; code_b3 = 4'b0111; code_b4 = 4'b1011;
        wave(5, 4, 4);

        repeat (16) tick(1'b0);
        #3;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule